// File: doc/BRIEF.md
# Ternary Rule Classifier

This block stores a small table of classification rules and, for each lookup key, returns the position of the best matching rule. Each rule has a value, a care mask and a valid flag. A key bit is compared only where the rule's mask bit is 1. Where the mask bit is 0, the rule accepts either key bit. The key is a fixed-width word that the surrounding logic assembles from chosen header fields.

Every stored rule is compared with the key in the same cycle. When more than one rule matches, a priority stage picks the one with the lowest index. The result is registered, so it appears one cycle after the lookup. A new lookup can be issued on every cycle. Rules are loaded one at a time through a write port. The block cannot compare against a numeric range directly. To cover a range, software splits it into several entries, each covering a power-of-two-sized block aligned to its own size.

Top module: `tcam_classifier`

## Requirements
- R1: While `rst` is high and in the cycle after it, `res_valid`, `res_hit` and `res_idx` are 0. Reset clears every rule's valid flag, so a lookup after reset misses until rules are written.
- R2: A rule matches a key when every key bit whose rule mask bit is 1 equals the rule value bit. Key bits whose mask bit is 0 are ignored.
- R3: A rule whose valid flag is 0 never matches, whatever its value and mask.
- R4: When several valid rules match, `res_idx` reports the lowest-numbered one.
- R5: When no rule matches a lookup, `res_valid` is 1, `res_hit` is 0 and `res_idx` is 0.
- R6: The result of a lookup presented with `lk_valid` high at a rising edge appears on the outputs after that edge, with `res_valid` high. Lookups on consecutive cycles each produce their own result on consecutive cycles.
- R7: A write presented at a rising edge affects lookups presented at later edges. A lookup presented at the same edge as the write still sees the old contents of that entry.
- R8: A numeric range that is stored as a set of aligned power-of-two blocks hits for every key inside the range and misses for keys just outside it. The index reported is that of the block that contains the key.
- R9: In a cycle after an edge where `lk_valid` was low, `res_valid`, `res_hit` and `res_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one rule this cycle |
| wr_idx | input | IDX_W (5) | Rule number to write |
| wr_value | input | KEY_W (32) | Rule value |
| wr_mask | input | KEY_W (32) | Care mask; 1 means compare this bit, 0 means ignore it |
| wr_valid | input | 1 | Valid flag stored with the rule |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_key | input | KEY_W (32) | Lookup key |
| res_valid | output | 1 | Registered: the result of a lookup is present |
| res_hit | output | 1 | Registered: at least one rule matched |
| res_idx | output | IDX_W (5) | Registered: lowest matching rule number, 0 on a miss |

## Verification
On every cycle, the assertions check the timing and cleanliness of the result port. A result follows each lookup by exactly one cycle. Idle cycles and reset give all-zero outputs. A miss always reports index 0, and a hit never appears without a valid result. Only the bench's scenarios can show that the matching is correct. These scenarios cover exact and masked comparison, invalid rules, lowest-index priority among overlapping rules, the ordering of a write against a lookup in the same cycle, and a range split into aligned blocks, checked at its edges and interior.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  parameter int unsigned DEF_ENTRIES = 32;
  parameter int unsigned DEF_KEY_W   = 32;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tcam_rule_array.sv
module tcam_rule_array #(
  parameter int unsigned ENTRIES = tcam_pkg::DEF_ENTRIES,
  parameter int unsigned KEY_W   = tcam_pkg::DEF_KEY_W,
  localparam int unsigned IDX_W  = tcam_pkg::idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_value,
  input  logic [KEY_W-1:0]   wr_mask,
  input  logic               wr_valid,
  input  logic [KEY_W-1:0]   key,
  output logic [ENTRIES-1:0] match
);
  // One storage slot and one comparator per rule.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_rule
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] care_q;
    logic             live_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (sel) begin
        val_q  <= wr_value;
        care_q <= wr_mask;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)      live_q <= 1'b0;
      else if (sel) live_q <= wr_valid;
    end

    assign match[e] = live_q && (((key ^ val_q) & care_q) == '0);
  end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int unsigned N      = tcam_pkg::DEF_ENTRIES,
  localparam int unsigned IDX_W = tcam_pkg::idx_width(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so the lowest set bit is written last and wins.
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tcam_classifier.sv
module tcam_classifier #(
  parameter int unsigned ENTRIES = tcam_pkg::DEF_ENTRIES,
  parameter int unsigned KEY_W   = tcam_pkg::DEF_KEY_W,
  localparam int unsigned IDX_W  = tcam_pkg::idx_width(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             wr_valid,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_key,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx
);
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   win_idx;

  tcam_rule_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) rules_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_value (wr_value),
    .wr_mask  (wr_mask),
    .wr_valid (wr_valid),
    .key      (lk_key),
    .match    (match_vec)
  );

  tcam_prio_enc #(.N(ENTRIES)) prio_i (
    .req (match_vec),
    .any (any_match),
    .idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_match;
      res_idx   <= (lk_valid && any_match) ? win_idx : '0;
    end
  end
endmodule

// File: rtl/tcam_classifier_chk.sv
module tcam_classifier_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_idx
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_hit && res_idx == '0));

  p_miss_index_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_idx == '0));

  p_result_follows_r6: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  p_idle_clean_r9: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!res_valid && !res_hit && res_idx == '0));

  p_hit_has_valid_r9: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
endmodule

bind tcam_classifier tcam_classifier_chk #(.IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_idx   (res_idx)
);

// File: tb/tcam_classifier_tb_top.sv
module tcam_classifier_tb_top;
  localparam int unsigned IDX_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [31:0]      wr_value = '0;
  logic [31:0]      wr_mask = '0;
  logic             wr_valid = 1'b0;
  logic             lk_valid = 1'b0;
  logic [31:0]      lk_key = '0;
  logic             res_valid;
  logic             res_hit;
  logic [IDX_W-1:0] res_idx;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tcam_classifier dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_valid(wr_valid),
    .lk_valid(lk_valid), .lk_key(lk_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
  );

  task automatic check_res(input string req, input logic ev, input logic eh,
                           input int ei);
    checks++;
    if (res_valid !== ev || res_hit !== eh || res_idx !== IDX_W'(ei)) begin
      fails++;
      $display("FAIL %s actual v=%0b h=%0b i=%0d expected v=%0b h=%0b i=%0d",
               req, res_valid, res_hit, res_idx, ev, eh, ei);
    end
  endtask

  task automatic write_rule(input int idx, input logic [31:0] v,
                            input logic [31:0] m, input logic ok);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_value = v; wr_mask = m; wr_valid = ok;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] k,
                        input logic eh, input int ei);
    @(negedge clk);
    lk_valid = 1'b1; lk_key = k;
    @(negedge clk);
    lk_valid = 1'b0;
    check_res(req, 1'b1, eh, ei);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_res("R1 during reset", 1'b0, 1'b0, 0);
    rst = 1'b0;
    @(negedge clk);
    check_res("R1 after reset", 1'b0, 1'b0, 0);
    lookup("R1 empty table", 32'h0000_0000, 1'b0, 0);
  endtask

  task automatic t_match;
    write_rule(5, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1);
    lookup("R2 exact", 32'hDEAD_BEEF, 1'b1, 5);
    lookup("R2 one bit off", 32'hDEAD_BEEE, 1'b0, 0);
    write_rule(9, 32'h1234_0000, 32'hFFFF_0000, 1'b1);
    lookup("R2 dont-care low half", 32'h1234_ABCD, 1'b1, 9);
    lookup("R2 cared bit differs", 32'h1235_ABCD, 1'b0, 0);
  endtask

  task automatic t_priority;
    write_rule(20, 32'h0, 32'h0, 1'b1);
    lookup("R4 5 over 20", 32'hDEAD_BEEF, 1'b1, 5);
    lookup("R4 only 20", 32'h0000_0000, 1'b1, 20);
    write_rule(2, 32'h0, 32'h0, 1'b1);
    lookup("R4 2 over 5 and 20", 32'hDEAD_BEEF, 1'b1, 2);
    write_rule(2, 32'h0, 32'h0, 1'b0);
    write_rule(20, 32'h0, 32'h0, 1'b0);
    lookup("R3 R5 catch-all rules cleared", 32'h0000_0000, 1'b0, 0);
    write_rule(5, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0);
    lookup("R3 invalid exact rule", 32'hDEAD_BEEF, 1'b0, 0);
  endtask

  task automatic t_write_order;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd7; wr_value = 32'hAAAA_5555;
    wr_mask = 32'hFFFF_FFFF; wr_valid = 1'b1;
    lk_valid = 1'b1; lk_key = 32'hAAAA_5555;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    check_res("R7 same-cycle lookup sees old", 1'b1, 1'b0, 0);
    lookup("R7 next lookup sees write", 32'hAAAA_5555, 1'b1, 7);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    lk_valid = 1'b1; lk_key = 32'hAAAA_5555;
    @(negedge clk);
    check_res("R6 stream first", 1'b1, 1'b1, 7);
    lk_key = 32'h0000_0001;
    @(negedge clk);
    check_res("R6 stream second", 1'b1, 1'b0, 0);
    lk_key = 32'h1234_FFFF;
    @(negedge clk);
    check_res("R6 stream third", 1'b1, 1'b1, 9);
    lk_valid = 1'b0; lk_key = 32'h1234_FFFF;
    @(negedge clk);
    check_res("R9 idle after stream", 1'b0, 1'b0, 0);
  endtask

  task automatic t_range;
    // 130..202 as aligned blocks: base and log2(size), in entries 24..31.
    int base [8] = '{130, 132, 136, 144, 160, 192, 200, 202};
    int lg   [8] = '{1,   2,   3,   4,   5,   3,   1,   0};
    for (int j = 0; j < 8; j++)
      write_rule(24 + j, 32'(base[j]), 32'hFFFF_FFFF << lg[j], 1'b1);
    lookup("R8 below range", 32'd129, 1'b0, 0);
    lookup("R8 low edge", 32'd130, 1'b1, 24);
    lookup("R8 131", 32'd131, 1'b1, 24);
    lookup("R8 150", 32'd150, 1'b1, 27);
    lookup("R8 191", 32'd191, 1'b1, 28);
    lookup("R8 192", 32'd192, 1'b1, 29);
    lookup("R8 201", 32'd201, 1'b1, 30);
    lookup("R8 high edge", 32'd202, 1'b1, 31);
    lookup("R8 above range", 32'd203, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_match();
    t_priority();
    t_write_order();
    t_back_to_back();
    t_range();
    @(negedge clk);
    check_res("R9 final idle", 1'b0, 1'b0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule